// File: doc/BRIEF.md
# Sixteen-Bit Reloading Timer with Square-Wave Output

This block is a 16-bit timer/counter kept as two cascaded 8-bit halves. A 16-bit companion register serves as the reload value or as the capture target, depending on the mode. A step comes from either a prescaled tick enable or a falling edge on an external count pin, and only while the run bit is set.

Three modes share the counter. The **reload** mode counts up by default. With down-count enabled, the level of the trigger pin picks the direction. The **capture** mode latches the running count when the trigger pin falls. The **square-wave** mode reloads on every overflow and flips an output pin, which gives a 50% duty clock whose period is set by the reload value.

Two sticky flags report events, and each flag is cleared by its own clear strobe. A byte-wide write port loads either half of the count or of the reload value. Both asynchronous pins pass through a two-flop synchroniser before any logic uses them.

Top module: `tmr16_clkout`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count_o`, `reload_o`, `ovf_o`, `ext_o` and `clk_out_o` are all zero.
- R2: A step occurs in a cycle where `run_i` is 1 and either (`src_ext_i`=0 and `tick_i`=1) or (`src_ext_i`=1 and a synchronised falling edge on `cnt_pin_i`). An up step adds one to the count. With `run_i`=0 the count holds, whatever the tick does.
- R3: When `src_ext_i`=1, the count advances once per falling edge of `cnt_pin_i` and `tick_i` is ignored.
- R4: In reload mode (`clk_out_en_i`=0, `cap_sel_i`=0), an up step from FFFFh loads `reload_o` into the count and sets `ovf_o`. `ovf_o` then stays set until `ovf_clr_i` is pulsed; a set in the same cycle wins over the clear.
- R5: In reload mode with `dn_en_i`=1, the synchronised `trig_i` level chooses the direction: 1 counts up and 0 counts down. A down step taken while the count equals `reload_o` loads FFFFh and sets `ovf_o`.
- R6: In reload mode with `dn_en_i`=1, `ext_o` inverts on every overflow or underflow. `ext_clr_i` clears it.
- R7: In capture mode (`cap_sel_i`=1, `clk_out_en_i`=0), a synchronised falling edge on `trig_i` copies the present count into `reload_o` and sets `ext_o`. An up step from FFFFh wraps the count to 0000h and sets `ovf_o`.
- R8: In square-wave mode (`clk_out_en_i`=1, which overrides `cap_sel_i`), an up step from FFFFh loads `reload_o` and inverts `clk_out_o` without setting `ovf_o`. While `clk_out_en_i`=0, `clk_out_o` is 0.
- R9: When `wr_en_i`=1, `wr_sel_i` picks the target: 0 is the count low byte, 1 the count high byte, 2 the reload low byte, 3 the reload high byte. The target is loaded with `wr_data_i` in place of any step or capture result for that register, and the other byte keeps its value.
- R10: A change on `trig_i` or `cnt_pin_i` takes effect on the third rising clock edge after it is applied, because of the two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled tick enable |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| trig_i | input | 1 | Asynchronous trigger / direction pin |
| run_i | input | 1 | Run enable |
| src_ext_i | input | 1 | 1: count pin edges, 0: tick |
| cap_sel_i | input | 1 | 1: capture mode, 0: reload mode |
| dn_en_i | input | 1 | Enable pin-controlled direction in reload mode |
| clk_out_en_i | input | 1 | Square-wave output mode |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ext_clr_i | input | 1 | Clears the external flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 8 | Write data byte |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload / capture register |
| ovf_o | output | 1 | Overflow flag |
| ext_o | output | 1 | External flag |
| clk_out_o | output | 1 | Square-wave output |

## Verification
The assertions assume that flags drop only through their clear strobes or through the direction-mode toggle. They also assume that the control bits are plain levels, sampled on every rising edge.

Every edge on the two pins is counted on only if each pin level is held for at least two clocks, so that the synchroniser sees it. The stimulus holds each pin level for two or more cycles and changes all inputs just after the falling clock edge. The mode bits change only while `run_i` is low or the counter is idle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_CLKOUT  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_REL_LO = 2'd2,
        SEL_REL_HI = 2'd3
    } wsel_e;

    typedef struct packed {
        mode_e mode;
        logic  step;
        logic  up;
        logic  cap;
    } ctl_t;

    function automatic mode_e pick_mode(input logic clk_out_en, input logic cap_sel);
        if (clk_out_en)
            return MODE_CLKOUT;
        else if (cap_sel)
            return MODE_CAPTURE;
        else
            return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign lvl  = sh_q[STAGES-1];
    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  ctl_t                ctl,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [2*HALF_W-1:0] count,
    output logic [2*HALF_W-1:0] reload,
    output logic                wrap
);
    localparam int CNT_W = 2 * HALF_W;

    logic [HALF_W-1:0] lo_q, hi_q, rlo_q, rhi_q;
    logic [HALF_W-1:0] lo_n, hi_n;
    logic              at_max, at_rel;

    assign count  = {hi_q, lo_q};
    assign reload = {rhi_q, rlo_q};
    assign at_max = &count;
    assign at_rel = (count == reload);

    // cascaded halves: high half moves on the low half's carry / borrow
    always_comb begin
        lo_n = lo_q;
        hi_n = hi_q;
        wrap = 1'b0;
        if (ctl.step) begin
            if (ctl.up) begin
                if (at_max) begin
                    wrap = 1'b1;
                    {hi_n, lo_n} = (ctl.mode == MODE_CAPTURE) ? {CNT_W{1'b0}} : reload;
                end else begin
                    lo_n = lo_q + 1'b1;
                    hi_n = hi_q + {{(HALF_W-1){1'b0}}, &lo_q};
                end
            end else begin
                if (at_rel) begin
                    wrap = 1'b1;
                    {hi_n, lo_n} = {CNT_W{1'b1}};
                end else begin
                    lo_n = lo_q - 1'b1;
                    hi_n = hi_q - {{(HALF_W-1){1'b0}}, (lo_q == '0)};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            hi_q  <= '0;
            rlo_q <= '0;
            rhi_q <= '0;
        end else begin
            lo_q <= (wr_en && wsel_e'(wr_sel) == SEL_CNT_LO) ? wr_data :
                    (wr_en && wsel_e'(wr_sel) == SEL_CNT_HI) ? lo_q : lo_n;
            hi_q <= (wr_en && wsel_e'(wr_sel) == SEL_CNT_HI) ? wr_data :
                    (wr_en && wsel_e'(wr_sel) == SEL_CNT_LO) ? hi_q : hi_n;
            if (wr_en && wsel_e'(wr_sel) == SEL_REL_LO)
                rlo_q <= wr_data;
            else if (ctl.cap)
                rlo_q <= lo_q;
            if (wr_en && wsel_e'(wr_sel) == SEL_REL_HI)
                rhi_q <= wr_data;
            else if (ctl.cap)
                rhi_q <= hi_q;
        end
    end
endmodule

// File: rtl/tmr16_clkout.sv
module tmr16_clkout
    import tmr16_pkg::*;
#(
    parameter int HALF_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                cnt_pin_i,
    input  logic                trig_i,
    input  logic                run_i,
    input  logic                src_ext_i,
    input  logic                cap_sel_i,
    input  logic                dn_en_i,
    input  logic                clk_out_en_i,
    input  logic                ovf_clr_i,
    input  logic                ext_clr_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [HALF_W-1:0]   wr_data_i,
    output logic [2*HALF_W-1:0] count_o,
    output logic [2*HALF_W-1:0] reload_o,
    output logic                ovf_o,
    output logic                ext_o,
    output logic                clk_out_o
);
    logic  trig_lvl, trig_fall, cnt_lvl, cnt_fall;
    logic  wrap;
    mode_e mode;
    ctl_t  ctl;

    tmr16_sync #(.STAGES(SYNC_STGS)) u_sync_trig (
        .clk(clk), .rst(rst), .pin(trig_i), .lvl(trig_lvl), .fall(trig_fall)
    );

    tmr16_sync #(.STAGES(SYNC_STGS)) u_sync_cnt (
        .clk(clk), .rst(rst), .pin(cnt_pin_i), .lvl(cnt_lvl), .fall(cnt_fall)
    );

    always_comb begin
        mode     = pick_mode(clk_out_en_i, cap_sel_i);
        ctl.mode = mode;
        ctl.step = run_i & (src_ext_i ? cnt_fall : tick_i);
        ctl.up   = (mode != MODE_RELOAD) | ~dn_en_i | trig_lvl;
        ctl.cap  = (mode == MODE_CAPTURE) & trig_fall;
    end

    tmr16_core #(.HALF_W(HALF_W)) u_core (
        .clk(clk), .rst(rst), .ctl(ctl),
        .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_data(wr_data_i),
        .count(count_o), .reload(reload_o), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_o     <= 1'b0;
            ext_o     <= 1'b0;
            clk_out_o <= 1'b0;
        end else begin
            if (wrap && mode != MODE_CLKOUT)
                ovf_o <= 1'b1;
            else if (ovf_clr_i)
                ovf_o <= 1'b0;

            if (wrap && mode == MODE_RELOAD && dn_en_i)
                ext_o <= ~ext_o;
            else if (ctl.cap)
                ext_o <= 1'b1;
            else if (ext_clr_i)
                ext_o <= 1'b0;

            if (mode != MODE_CLKOUT)
                clk_out_o <= 1'b0;
            else if (wrap)
                clk_out_o <= ~clk_out_o;
        end
    end

    logic unused_lvl;
    assign unused_lvl = cnt_lvl;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int HALF_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                run_i,
    input logic                clk_out_en_i,
    input logic                ovf_clr_i,
    input logic                wr_en_i,
    input logic [1:0]          wr_sel_i,
    input logic [HALF_W-1:0]   wr_data_i,
    input logic [2*HALF_W-1:0] count_o,
    input logic [2*HALF_W-1:0] reload_o,
    input logic                ovf_o,
    input logic                clk_out_o
);
    // R2: no run and no write leaves the count untouched
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !wr_en_i) |=> $stable(count_o));

    // R4: only the clear strobe drops the overflow flag
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_o) |-> $past(ovf_clr_i));

    // R8: square-wave mode never raises the overflow flag
    a_r8_no_ovf_clkout: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(!clk_out_en_i));

    // R8: output pin is low whenever the mode is off
    a_r8_pin_idle: assert property (@(posedge clk) disable iff (rst)
        !clk_out_en_i |=> !clk_out_o);

    // R9: reload low byte write lands as written
    a_r9_wr_rel_lo: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 2'd2) |=> (reload_o[HALF_W-1:0] == $past(wr_data_i)));

    // R9: count high byte write lands as written
    a_r9_wr_cnt_hi: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 2'd1) |=> (count_o[2*HALF_W-1:HALF_W] == $past(wr_data_i)));
endmodule

bind tmr16_clkout tmr16_chk #(.HALF_W(HALF_W)) u_chk (
    .clk(clk), .rst(rst), .run_i(run_i), .clk_out_en_i(clk_out_en_i),
    .ovf_clr_i(ovf_clr_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .reload_o(reload_o),
    .ovf_o(ovf_o), .clk_out_o(clk_out_o)
);

// File: tb/tb_tmr16_clkout.sv
module tb_tmr16_clkout;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_i, cnt_pin_i, trig_i, run_i, src_ext_i, cap_sel_i;
    logic        dn_en_i, clk_out_en_i, ovf_clr_i, ext_clr_i, wr_en_i;
    logic [1:0]  wr_sel_i;
    logic [7:0]  wr_data_i;
    logic [15:0] count_o, reload_o;
    logic        ovf_o, ext_o, clk_out_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr16_clkout dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i), .trig_i(trig_i),
        .run_i(run_i), .src_ext_i(src_ext_i), .cap_sel_i(cap_sel_i), .dn_en_i(dn_en_i),
        .clk_out_en_i(clk_out_en_i), .ovf_clr_i(ovf_clr_i), .ext_clr_i(ext_clr_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .count_o(count_o), .reload_o(reload_o), .ovf_o(ovf_o), .ext_o(ext_o),
        .clk_out_o(clk_out_o)
    );

    // behavioural reference
    int m_cnt, m_rel;
    bit m_ovf, m_ext, m_clk;
    bit t_hist[$];
    bit c_hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rel = 0; m_ovf = 0; m_ext = 0; m_clk = 0;
            t_hist = '{0, 0, 0};
            c_hist = '{0, 0, 0};
        end else begin
            bit tl, tf, cf, co, cap, ar, step, up, wrap, capev, e;
            int ncnt, nrel;
            tl = t_hist[1];
            tf = t_hist[2] && !t_hist[1];
            cf = c_hist[2] && !c_hist[1];
            co = clk_out_en_i;
            cap = !co && cap_sel_i;
            ar = !co && !cap_sel_i;
            step = run_i && (src_ext_i ? cf : tick_i);
            up = !ar || !dn_en_i || tl;
            wrap = 0;
            ncnt = m_cnt;
            if (step) begin
                if (up) begin
                    if (m_cnt == 65535) begin wrap = 1; ncnt = cap ? 0 : m_rel; end
                    else ncnt = m_cnt + 1;
                end else begin
                    if (m_cnt == m_rel) begin wrap = 1; ncnt = 65535; end
                    else ncnt = (m_cnt - 1) & 65535;
                end
            end
            capev = cap && tf;
            nrel = capev ? m_cnt : m_rel;
            if (wr_en_i) begin
                case (wr_sel_i)
                    2'd0: ncnt = (m_cnt & 16'hFF00) | int'(wr_data_i);
                    2'd1: ncnt = (m_cnt & 16'h00FF) | (int'(wr_data_i) << 8);
                    2'd2: nrel = (nrel & 16'hFF00) | int'(wr_data_i);
                    default: nrel = (nrel & 16'h00FF) | (int'(wr_data_i) << 8);
                endcase
            end
            if (wrap && !co) m_ovf = 1;
            else if (ovf_clr_i) m_ovf = 0;
            e = ext_clr_i ? 0 : m_ext;
            if (capev) e = 1;
            if (wrap && ar && dn_en_i) e = !m_ext;
            m_ext = e;
            m_clk = co ? (wrap ? !m_clk : m_clk) : 0;
            m_cnt = ncnt;
            m_rel = nrel;
            void'(t_hist.pop_back());
            t_hist.push_front(trig_i);
            void'(c_hist.pop_back());
            c_hist.push_front(cnt_pin_i);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 count vs model", int'(count_o), m_cnt);
            chk("R9 reload vs model", int'(reload_o), m_rel);
            chk("R4 ovf vs model", int'(ovf_o), int'(m_ovf));
            chk("R6 ext vs model", int'(ext_o), int'(m_ext));
            chk("R8 clk_out vs model", int'(clk_out_o), int'(m_clk));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
        wait_n(1);
        wr_en_i = 0;
    endtask

    task automatic pulse_clr;
        ovf_clr_i = 1; ext_clr_i = 1;
        wait_n(1);
        ovf_clr_i = 0; ext_clr_i = 0;
    endtask

    initial begin
        rst = 1; tick_i = 0; cnt_pin_i = 0; trig_i = 0; run_i = 0; src_ext_i = 0;
        cap_sel_i = 0; dn_en_i = 0; clk_out_en_i = 0; ovf_clr_i = 0; ext_clr_i = 0;
        wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
        wait_n(3);
        rst = 0;
        wait_n(1);
        // R1 reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 reload", int'(reload_o), 0);
        chk("R1 flags", int'({ovf_o, ext_o, clk_out_o}), 0);

        // R2 tick counting, then stopped
        run_i = 1; tick_i = 1;
        wait_n(5);
        tick_i = 0;
        chk("R2 five ticks", int'(count_o), 5);
        run_i = 0; tick_i = 1;
        wait_n(3);
        tick_i = 0;
        chk("R2 run low holds", int'(count_o), 5);

        // R4 up overflow reload, R9 writes
        wr(2'd2, 8'hF0); wr(2'd3, 8'hFF);
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        chk("R9 count write", int'(count_o), 16'hFFFE);
        chk("R9 reload write", int'(reload_o), 16'hFFF0);
        run_i = 1; tick_i = 1;
        wait_n(2);
        tick_i = 0;
        chk("R4 reload on overflow", int'(count_o), 16'hFFF0);
        chk("R4 ovf set", int'(ovf_o), 1);
        wait_n(2);
        chk("R4 ovf sticky", int'(ovf_o), 1);
        pulse_clr();
        chk("R4 ovf cleared", int'(ovf_o), 0);

        // R5 / R6 down counting
        run_i = 0; dn_en_i = 1;
        wr(2'd2, 8'h10); wr(2'd3, 8'h00);
        wr(2'd0, 8'h12); wr(2'd1, 8'h00);
        run_i = 1; tick_i = 1;
        wait_n(2);
        chk("R5 counts down", int'(count_o), 16'h0010);
        wait_n(1);
        tick_i = 0;
        chk("R5 underflow to FFFF", int'(count_o), 16'hFFFF);
        chk("R5 ovf on underflow", int'(ovf_o), 1);
        chk("R6 ext toggles high", int'(ext_o), 1);
        trig_i = 1;
        wait_n(3);
        tick_i = 1;
        wait_n(1);
        tick_i = 0;
        chk("R5 up direction reloads", int'(count_o), 16'h0010);
        chk("R6 ext toggles low", int'(ext_o), 0);
        trig_i = 0;
        wait_n(4);
        pulse_clr();

        // R3 external count pin
        run_i = 0; dn_en_i = 0; src_ext_i = 1;
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        run_i = 1; tick_i = 1;
        for (int i = 0; i < 3; i++) begin
            cnt_pin_i = 1; wait_n(2);
            cnt_pin_i = 0; wait_n(2);
        end
        wait_n(2);
        tick_i = 0;
        chk("R3 three pin edges", int'(count_o), 3);

        // R7 / R10 capture
        run_i = 0; src_ext_i = 0; cap_sel_i = 1;
        wr(2'd0, 8'h34); wr(2'd1, 8'h12);
        trig_i = 1;
        wait_n(4);
        trig_i = 0;
        wait_n(2);
        chk("R10 not yet captured", int'(reload_o), 16'h0010);
        wait_n(1);
        chk("R7 capture value", int'(reload_o), 16'h1234);
        chk("R7 ext set on capture", int'(ext_o), 1);
        pulse_clr();
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        run_i = 1; tick_i = 1;
        wait_n(1);
        tick_i = 0;
        chk("R7 wrap to zero", int'(count_o), 0);
        chk("R7 ovf set", int'(ovf_o), 1);
        pulse_clr();

        // R8 square-wave output
        run_i = 0; cap_sel_i = 0; clk_out_en_i = 1;
        wr(2'd2, 8'hFE); wr(2'd3, 8'hFF);
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        run_i = 1; tick_i = 1;
        wait_n(2);
        chk("R8 first toggle", int'(clk_out_o), 1);
        chk("R8 reload", int'(count_o), 16'hFFFE);
        wait_n(2);
        chk("R8 second toggle", int'(clk_out_o), 0);
        wait_n(2);
        tick_i = 0;
        chk("R8 third toggle", int'(clk_out_o), 1);
        chk("R8 no ovf", int'(ovf_o), 0);
        clk_out_en_i = 0; run_i = 0;
        wait_n(1);
        chk("R8 pin low when off", int'(clk_out_o), 0);

        // R9 write priority over a step
        wr(2'd0, 8'h00); wr(2'd1, 8'h01);
        run_i = 1; tick_i = 1;
        wr(2'd0, 8'h55);
        chk("R9 write beats step", int'(count_o), 16'h0155);
        wait_n(1);
        tick_i = 0; run_i = 0;
        chk("R9 step after write", int'(count_o), 16'h0156);

        wait_n(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule